// File: doc/BRIEF.md
# Single-Cycle 8-bit Processor Core

This block is a small processor core for control tasks. Program storage and data storage sit on separate ports. Each clock cycle it fetches one 17-bit instruction word from a 256-entry program store and executes it completely. The core reads data storage combinationally. Writes to data storage happen on the next rising clock edge. Sixteen 8-bit general registers make up the whole architectural state, together with four condition flags (zero, carry, negative, overflow). Entry 14 is the stack pointer and entry 15 is the program counter, so an ordinary instruction can address either one.

The core has a two-state controller. In reset it sits in `ST_WAKE`. The first clock edge after reset is released takes it to `ST_RUN` without executing anything (transition WAKE_TO_RUN). It then stays in `ST_RUN` for good (transition RUN_HOLD) and executes one instruction per cycle. A stack grows downward: the pointer always names the next free byte.

Instruction word fields, from the top bit down: group [16:15], op [14:13], imm [12], field A [11:8], field B [7:4], field C [3:0]. Any immediate form that needs an 8-bit constant builds it as {B, C}.

Top module: `mcu8_core`

## Requirements
- R1: While reset is held, the program address is 0 and no data write occurs. The first cycle after release is a wake cycle with no data write. Execution then starts at address 0 with the stack pointer at 255 and every flag clear.
- R2: Group 10 (op 00 add, 01 subtract, 10 shift left, 11 shift right) and group 11 (op 00 AND, 01 OR, 10 XOR) with imm=0 write reg[A] = reg[B] op reg[C]. A shift by 8 or more gives 0.
- R3: With imm=1, the arithmetic and shift ops take C zero-extended as the second operand. The logic ops take a one-hot mask 1<<C instead, and that mask is 0 when C is 8 or more.
- R4: Group 00 op 00 loads reg[A] from memory, op 01 stores reg[A] to memory, and op 10 moves a value into reg[A]. With imm=1 the address or value is {B,C}. With imm=0 it is reg[B] plus C sign-extended, taken modulo 256. A move with imm=0 copies reg[B]. A load never writes memory.
- R5: Only moves and group 10/11 operations update the flags. Z is set when the result is 0. N is result bit 7. C is the carry out on add and is set on subtract when no borrow occurs; it is 0 otherwise. V is two's-complement overflow on add and subtract and 0 otherwise.
- R6: Group 00 op 11 is a branch whose condition is field A: 0 always, 1 Z set, 2 Z clear, 3 C set, 4 C clear, 5 N xor V, 6 not (N xor V), 7 to 15 never. A taken branch goes to {B,C} (imm=1) or to reg[B] plus C sign-extended (imm=0).
- R7: Push (group 01 op 00) writes reg[A] at the stack pointer and then decrements it. Pop (group 01 op 10) reads from pointer+1 into reg[A] and increments the pointer. If the pop target is register 14, the loaded value takes precedence over the increment.
- R8: Call (group 01 op 01) writes the return address (pc+1) at the stack pointer, decrements the pointer and jumps to {B,C} or to reg[B]. A pop into register 15 returns.
- R9: A load, move, pop or ALU operation whose destination is register 15 sets the next program address to the written value.
- R10: Group 01 op 11 and group 11 op 11 do nothing except advance the program address.
- R11: Every instruction that does not redirect control advances the program address by one, and the address wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pmem_addr | output | 8 | Program store address (current program counter) |
| pmem_data | input | 17 | Instruction word at pmem_addr, combinational |
| dmem_addr | output | 8 | Data store address |
| dmem_wdata | output | 8 | Data store write value |
| dmem_we | output | 1 | Data store write enable, written at the next rising edge |
| dmem_rdata | input | 8 | Data store read value at dmem_addr, combinational |

## Verification
The bound assertions check, on every cycle, the controller-level behaviour that a single instruction fully determines. They cover: no data write in the wake cycle or during a load or a no-op; push, pop and call placing their stack accesses at the pointer and moving it by one; never-taken condition codes and non-redirecting ALU work advancing the program address by one; and call storing pc+1. Flag arithmetic, the one-hot logic mask, sign-extended offsets, the destination-15 redirect, and return through pop can only be shown by running scenarios. For those, the bench compares every fetch address and every memory access against its own instruction model, over a directed program and over random instruction streams.

// File: rtl/mcu8_pkg.sv
package mcu8_pkg;

    // width of a register index field inside the instruction word
    localparam int FW = 4;

    typedef enum logic [0:0] {
        ST_WAKE = 1'b0,
        ST_RUN  = 1'b1
    } core_state_e;

    typedef enum logic [3:0] {
        K_NOP,
        K_LOAD,
        K_STORE,
        K_MOVE,
        K_BRANCH,
        K_PUSH,
        K_CALL,
        K_POP,
        K_ALU
    } kind_e;

    typedef enum logic [2:0] {
        A_ADD,
        A_SUB,
        A_SHL,
        A_SHR,
        A_AND,
        A_OR,
        A_XOR,
        A_PASS
    } alu_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

    typedef struct packed {
        kind_e           kind;
        alu_e            alu;
        logic            imm;
        logic            bitmask;
        logic [FW-1:0]   fa;
        logic [FW-1:0]   fb;
        logic [FW-1:0]   fc;
    } dec_t;

endpackage

// File: rtl/mcu8_decode.sv
module mcu8_decode
    import mcu8_pkg::*;
#(
    parameter int IW = 17
) (
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    logic [1:0] grp;
    logic [1:0] op;

    assign grp = instr[IW-1 -: 2];
    assign op  = instr[IW-3 -: 2];

    always_comb begin
        dec.kind    = K_NOP;
        dec.alu     = A_PASS;
        dec.imm     = instr[IW-5];
        dec.bitmask = (grp == 2'b11);
        dec.fa      = instr[3*FW-1 -: FW];
        dec.fb      = instr[2*FW-1 -: FW];
        dec.fc      = instr[FW-1:0];
        unique case ({grp, op})
            4'b0000: dec.kind = K_LOAD;
            4'b0001: dec.kind = K_STORE;
            4'b0010: dec.kind = K_MOVE;
            4'b0011: dec.kind = K_BRANCH;
            4'b0100: dec.kind = K_PUSH;
            4'b0101: dec.kind = K_CALL;
            4'b0110: dec.kind = K_POP;
            4'b1000: begin dec.kind = K_ALU; dec.alu = A_ADD; end
            4'b1001: begin dec.kind = K_ALU; dec.alu = A_SUB; end
            4'b1010: begin dec.kind = K_ALU; dec.alu = A_SHL; end
            4'b1011: begin dec.kind = K_ALU; dec.alu = A_SHR; end
            4'b1100: begin dec.kind = K_ALU; dec.alu = A_AND; end
            4'b1101: begin dec.kind = K_ALU; dec.alu = A_OR;  end
            4'b1110: begin dec.kind = K_ALU; dec.alu = A_XOR; end
            default: dec.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/mcu8_alu.sv
module mcu8_alu
    import mcu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_e          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output flags_t        fl
);
    logic [DW:0] sum;
    logic [DW:0] diff;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign diff = {1'b0, a} - {1'b0, b};

    always_comb begin
        y    = b;
        fl.c = 1'b0;
        fl.v = 1'b0;
        unique case (op)
            A_ADD: begin
                y    = sum[DW-1:0];
                fl.c = sum[DW];
                fl.v = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
            end
            A_SUB: begin
                y    = diff[DW-1:0];
                fl.c = ~diff[DW];
                fl.v = (a[DW-1] != b[DW-1]) && (diff[DW-1] != a[DW-1]);
            end
            A_SHL:  y = a << b;
            A_SHR:  y = a >> b;
            A_AND:  y = a & b;
            A_OR:   y = a | b;
            A_XOR:  y = a ^ b;
            A_PASS: y = b;
            default: y = b;
        endcase
        fl.z = (y == '0);
        fl.n = y[DW-1];
    end
endmodule

// File: rtl/mcu8_cond.sv
module mcu8_cond
    import mcu8_pkg::*;
(
    input  flags_t        fl,
    input  logic [FW-1:0] code,
    output logic          take
);
    logic slt;
    assign slt = fl.n ^ fl.v;

    always_comb begin
        unique case (code)
            4'd0:    take = 1'b1;
            4'd1:    take = fl.z;
            4'd2:    take = ~fl.z;
            4'd3:    take = fl.c;
            4'd4:    take = ~fl.c;
            4'd5:    take = slt;
            4'd6:    take = ~slt;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/mcu8_regfile.sv
module mcu8_regfile
    import mcu8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] ra_idx,
    input  logic [FW-1:0] rb_idx,
    output logic [DW-1:0] ra,
    output logic [DW-1:0] rb,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] pc_q,
    input  logic          wen,
    input  logic [FW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic          sp_wen,
    input  logic [DW-1:0] sp_wdata,
    input  logic          pc_wen,
    input  logic [DW-1:0] pc_wdata
);
    localparam int SP_IDX = NREG - 2;
    localparam int PC_IDX = NREG - 1;

    logic [DW-1:0] regs [NREG];

    // priority per entry: program counter path, then destination, then pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= (i == SP_IDX) ? '1 : '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (pc_wen && (i == PC_IDX)) begin
                    regs[i] <= pc_wdata;
                end else if (wen && (widx == FW'(i))) begin
                    regs[i] <= wdata;
                end else if (sp_wen && (i == SP_IDX)) begin
                    regs[i] <= sp_wdata;
                end
            end
        end
    end

    assign ra   = regs[ra_idx];
    assign rb   = regs[rb_idx];
    assign sp_q = regs[SP_IDX];
    assign pc_q = regs[PC_IDX];
endmodule

// File: rtl/mcu8_core.sv
module mcu8_core
    import mcu8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int IW   = 17,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] pmem_addr,
    input  logic [IW-1:0] pmem_data,
    output logic [DW-1:0] dmem_addr,
    output logic [DW-1:0] dmem_wdata,
    output logic          dmem_we,
    input  logic [DW-1:0] dmem_rdata
);
    localparam logic [FW-1:0] PC_ID = FW'(NREG - 1);
    localparam logic [DW-1:0] ONE   = DW'(1);

    core_state_e   state_q, state_n;
    logic          exec_en;

    dec_t          dec;
    flags_t        flags_q, alu_fl;
    logic          take;

    logic [FW-1:0] rb_idx;
    logic [DW-1:0] ra, rb, sp_q, pc_q;
    logic [DW-1:0] off_ext, konst, reg_ea, eff_addr, mask, alu_b, alu_y;
    logic [DW-1:0] pc_inc, sp_inc, sp_dec, pc_next, rd_data, sp_wdata;
    logic          rd_we, sp_we, flags_we, rf_wen;

    // ---------------- controller: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAKE;
        else        state_q <= state_n;
    end

    // ---------------- controller: next state and outputs ----------------
    always_comb begin
        unique case (state_q)
            ST_WAKE: state_n = ST_RUN;   // WAKE_TO_RUN
            ST_RUN:  state_n = ST_RUN;   // RUN_HOLD
            default: state_n = ST_WAKE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_WAKE: exec_en = 1'b0;
            ST_RUN:  exec_en = 1'b1;
            default: exec_en = 1'b0;
        endcase
    end

    // ---------------- decode ----------------
    mcu8_decode #(.IW(IW)) u_dec (
        .instr (pmem_data),
        .dec   (dec)
    );

    assign rb_idx = (dec.kind == K_ALU) ? dec.fc : dec.fa;

    mcu8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (dec.fb),
        .rb_idx   (rb_idx),
        .ra       (ra),
        .rb       (rb),
        .sp_q     (sp_q),
        .pc_q     (pc_q),
        .wen      (rf_wen),
        .widx     (dec.fa),
        .wdata    (rd_data),
        .sp_wen   (sp_we),
        .sp_wdata (sp_wdata),
        .pc_wen   (exec_en),
        .pc_wdata (pc_next)
    );

    // ---------------- operand formation ----------------
    assign off_ext  = {{(DW-FW){dec.fc[FW-1]}}, dec.fc};
    assign konst    = DW'({dec.fb, dec.fc});
    assign reg_ea   = ra + off_ext;
    assign eff_addr = dec.imm ? konst : reg_ea;
    assign mask     = ONE << dec.fc;
    assign pc_inc   = pc_q + ONE;
    assign sp_inc   = sp_q + ONE;
    assign sp_dec   = sp_q - ONE;

    always_comb begin
        unique case (dec.kind)
            K_MOVE:  alu_b = dec.imm ? konst : ra;
            K_ALU:   alu_b = dec.imm ? (dec.bitmask ? mask : DW'(dec.fc)) : rb;
            default: alu_b = '0;
        endcase
    end

    mcu8_alu #(.DW(DW)) u_alu (
        .op (dec.alu),
        .a  (ra),
        .b  (alu_b),
        .y  (alu_y),
        .fl (alu_fl)
    );

    mcu8_cond u_cond (
        .fl   (flags_q),
        .code (dec.fa),
        .take (take)
    );

    // ---------------- execute ----------------
    always_comb begin
        dmem_we    = 1'b0;
        dmem_addr  = eff_addr;
        dmem_wdata = rb;
        rd_we      = 1'b0;
        rd_data    = alu_y;
        sp_we      = 1'b0;
        sp_wdata   = sp_q;
        flags_we   = 1'b0;
        pc_next    = pc_inc;
        unique case (dec.kind)
            K_LOAD: begin
                rd_we   = 1'b1;
                rd_data = dmem_rdata;
            end
            K_STORE: begin
                dmem_we = 1'b1;
            end
            K_MOVE, K_ALU: begin
                rd_we    = 1'b1;
                flags_we = 1'b1;
            end
            K_BRANCH: begin
                if (take) pc_next = eff_addr;
            end
            K_PUSH: begin
                dmem_addr = sp_q;
                dmem_we   = 1'b1;
                sp_we     = 1'b1;
                sp_wdata  = sp_dec;
            end
            K_CALL: begin
                dmem_addr  = sp_q;
                dmem_wdata = pc_inc;
                dmem_we    = 1'b1;
                sp_we      = 1'b1;
                sp_wdata   = sp_dec;
                pc_next    = dec.imm ? konst : ra;
            end
            K_POP: begin
                dmem_addr = sp_inc;
                rd_we     = 1'b1;
                rd_data   = dmem_rdata;
                sp_we     = 1'b1;
                sp_wdata  = sp_inc;
            end
            default: ;
        endcase
        if (rd_we && (dec.fa == PC_ID)) begin
            pc_next = rd_data;
        end
        if (!exec_en) begin
            dmem_we  = 1'b0;
            rd_we    = 1'b0;
            sp_we    = 1'b0;
            flags_we = 1'b0;
            pc_next  = pc_q;
        end
    end

    assign rf_wen    = rd_we && (dec.fa != PC_ID);
    assign pmem_addr = pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flags_q <= '0;
        else if (flags_we) flags_q <= alu_fl;
    end
endmodule

// File: rtl/mcu8_core_chk.sv
module mcu8_core_chk #(
    parameter int DW = 8,
    parameter int IW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_en,
    input logic [DW-1:0] sp_q,
    input logic [DW-1:0] pmem_addr,
    input logic [IW-1:0] pmem_data,
    input logic [DW-1:0] dmem_addr,
    input logic [DW-1:0] dmem_wdata,
    input logic          dmem_we
);
    logic [3:0] go;
    logic [3:0] fa;
    assign go = pmem_data[IW-1 -: 4];
    assign fa = pmem_data[11:8];

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |-> !dmem_we);                                                  // R1
    AST_WAKE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |-> (pmem_addr == '0));                                         // R1
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && go == 4'b0000) |-> !dmem_we);                                // R4
    AST_NEVER_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && go == 4'b0011 && fa >= 4'd7) |=> (pmem_addr == DW'($past(pmem_addr) + 1'b1))); // R6
    AST_PUSH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && go == 4'b0100) |-> (dmem_we && dmem_addr == sp_q));        // R7
    AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && go == 4'b0100) |=> (sp_q == DW'($past(sp_q) - 1'b1)));     // R7
    AST_POP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && go == 4'b0110) |-> (!dmem_we && dmem_addr == DW'(sp_q + 1'b1))); // R7
    AST_POP_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && go == 4'b0110 && fa != 4'd14) |=> (sp_q == DW'($past(sp_q) + 1'b1))); // R7
    AST_CALL_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && go == 4'b0101) |-> (dmem_we && dmem_addr == sp_q && dmem_wdata == DW'(pmem_addr + 1'b1))); // R8
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (go == 4'b0111 || go == 4'b1111)) |-> !dmem_we);            // R10
    AST_NOP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (go == 4'b0111 || go == 4'b1111)) |=> (pmem_addr == DW'($past(pmem_addr) + 1'b1))); // R10
    AST_ALU_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && pmem_data[IW-1] && fa != 4'hF) |=> (pmem_addr == DW'($past(pmem_addr) + 1'b1))); // R11
endmodule

bind mcu8_core mcu8_core_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_en    (exec_en),
    .sp_q       (sp_q),
    .pmem_addr  (pmem_addr),
    .pmem_data  (pmem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we)
);

// File: tb/tb_mcu8_core.sv
module tb_mcu8_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pmem_addr;
    logic [16:0] pmem_data;
    logic [7:0]  dmem_addr;
    logic [7:0]  dmem_wdata;
    logic        dmem_we;
    logic [7:0]  dmem_rdata;

    logic [16:0] rom  [256];
    logic [7:0]  ram  [256];
    logic [7:0]  mram [256];
    logic [7:0]  mreg [16];
    logic        mz, mc, mn, mv;

    int total = 0;
    int bad   = 0;
    string prev_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu8_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pmem_addr  (pmem_addr),
        .pmem_data  (pmem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign pmem_data  = rom[pmem_addr];
    assign dmem_rdata = ram[dmem_addr];

    always @(posedge clk) begin
        if (dmem_we) ram[dmem_addr] <= dmem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] enc(input int g, input int o, input int im,
                                        input int a, input int b, input int c);
        return {2'(g), 2'(o), 1'(im), 4'(a), 4'(b), 4'(c)};
    endfunction

    function automatic logic cond_ok(input logic [3:0] code);
        case (code)
            4'd0: return 1'b1;
            4'd1: return mz;
            4'd2: return !mz;
            4'd3: return mc;
            4'd4: return !mc;
            4'd5: return mn ^ mv;
            4'd6: return !(mn ^ mv);
            default: return 1'b0;
        endcase
    endfunction

    // instruction model: returns the expected memory access and advances the model state
    task automatic model_step(input logic [16:0] ins, output logic ewe, output logic eav,
                              output logic [7:0] eaddr, output logic [7:0] ewd, output string tag);
        logic [1:0] g, o;
        logic       im;
        logic [3:0] a1, a2, a3;
        logic [7:0] pc, npc, soff, k8, ea, val, opa, opb;
        logic [8:0] wide;
        logic       wr;
        g = ins[16:15]; o = ins[14:13]; im = ins[12];
        a1 = ins[11:8]; a2 = ins[7:4]; a3 = ins[3:0];
        pc = mreg[15]; npc = pc + 8'd1;
        soff = {{4{a3[3]}}, a3}; k8 = {a2, a3};
        ea = im ? k8 : 8'(mreg[a2] + soff);
        ewe = 1'b0; eav = 1'b0; eaddr = 8'h0; ewd = 8'h0; wr = 1'b0; val = 8'h0;
        tag = "R10";
        case ({g, o})
            4'b0000: begin tag = "R4"; eav = 1'b1; eaddr = ea; val = mram[ea]; wr = 1'b1; end
            4'b0001: begin tag = "R4"; ewe = 1'b1; eaddr = ea; ewd = mreg[a1]; mram[ea] = mreg[a1]; end
            4'b0010: begin
                tag = "R4"; val = im ? k8 : mreg[a2]; wr = 1'b1;
                mz = (val == 0); mn = val[7]; mc = 1'b0; mv = 1'b0;
            end
            4'b0011: begin tag = "R6"; if (cond_ok(a1)) npc = ea; end
            4'b0100: begin
                tag = "R7"; ewe = 1'b1; eaddr = mreg[14]; ewd = mreg[a1];
                mram[mreg[14]] = mreg[a1]; mreg[14] = mreg[14] - 8'd1;
            end
            4'b0101: begin
                tag = "R8"; ewe = 1'b1; eaddr = mreg[14]; ewd = pc + 8'd1;
                mram[mreg[14]] = pc + 8'd1; npc = im ? k8 : mreg[a2];
                mreg[14] = mreg[14] - 8'd1;
            end
            4'b0110: begin
                tag = "R7"; eav = 1'b1; eaddr = mreg[14] + 8'd1; val = mram[eaddr];
                mreg[14] = mreg[14] + 8'd1; wr = 1'b1;
            end
            4'b0111, 4'b1111: tag = "R10";
            default: begin
                tag = im ? "R3" : "R2";
                opa = mreg[a2];
                if (!im)         opb = mreg[a3];
                else if (g == 2'b11) opb = (a3 < 4'd8) ? (8'd1 << a3) : 8'd0;
                else             opb = {4'd0, a3};
                mc = 1'b0; mv = 1'b0;
                case ({g, o})
                    4'b1000: begin
                        wide = {1'b0, opa} + {1'b0, opb}; val = wide[7:0]; mc = wide[8];
                        mv = (opa[7] == opb[7]) && (val[7] != opa[7]);
                    end
                    4'b1001: begin
                        wide = {1'b0, opa} - {1'b0, opb}; val = wide[7:0]; mc = !wide[8];
                        mv = (opa[7] != opb[7]) && (val[7] != opa[7]);
                    end
                    4'b1010: val = (opb >= 8) ? 8'd0 : 8'(opa << opb[2:0]);
                    4'b1011: val = (opb >= 8) ? 8'd0 : (opa >> opb[2:0]);
                    4'b1100: val = opa & opb;
                    4'b1101: val = opa | opb;
                    default: val = opa ^ opb;
                endcase
                mz = (val == 0); mn = val[7]; wr = 1'b1;
            end
        endcase
        if (wr) begin
            if (a1 == 4'd15) begin npc = val; tag = "R9"; end
            else mreg[a1] = val;
        end
        mreg[15] = npc;
    endtask

    task automatic run_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            logic [16:0] ins;
            logic ewe, eav;
            logic [7:0] eaddr, ewd;
            string tag;
            @(negedge clk);
            chk(pmem_addr == mreg[15], (prev_tag == "R10") ? "R10" : prev_tag,
                "program address", pmem_addr, mreg[15]);
            ins = rom[mreg[15]];
            model_step(ins, ewe, eav, eaddr, ewd, tag);
            chk(dmem_we == ewe, tag, "write enable", dmem_we, ewe);
            if (ewe) begin
                chk(dmem_addr == eaddr, tag, "write address", dmem_addr, eaddr);
                chk(dmem_wdata == ewd, tag, "write data", dmem_wdata, ewd);
            end else if (eav) begin
                chk(dmem_addr == eaddr, tag, "read address", dmem_addr, eaddr);
            end
            prev_tag = tag;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin ram[i] = 8'h0; mram[i] = 8'h0; end
        for (int i = 0; i < 16; i++) mreg[i] = 8'h0;
        mreg[14] = 8'hFF; mz = 0; mc = 0; mn = 0; mv = 0;
        prev_tag = "R1";
        repeat (3) @(negedge clk);
        chk(pmem_addr == 8'h0, "R1", "address in reset", pmem_addr, 0);
        chk(dmem_we == 1'b0, "R1", "write in reset", dmem_we, 0);
        rst_n = 1'b1;
        #1;
        chk(dmem_we == 1'b0, "R1", "write in wake cycle", dmem_we, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd90210));
        for (int i = 0; i < 256; i++) rom[i] = enc(3, 3, 0, 0, 0, 0);

        // directed program
        rom[8'h00] = enc(0, 3, 1, 1, 3, 15);     // branch if Z to 0x3F: flags clear, not taken (R1)
        rom[8'h01] = enc(0, 2, 1, 1, 12, 8);     // r1 = 0xC8
        rom[8'h02] = enc(2, 0, 0, 2, 1, 1);      // r2 = r1 + r1 = 0x90, carry set
        rom[8'h03] = enc(0, 1, 1, 2, 1, 0);      // [0x10] = r2
        rom[8'h04] = enc(0, 3, 1, 3, 0, 7);      // branch if C to 7 (taken)
        rom[8'h05] = enc(0, 2, 1, 3, 5, 5);      // skipped
        rom[8'h06] = enc(0, 1, 1, 3, 1, 1);      // skipped
        rom[8'h07] = enc(1, 1, 1, 0, 2, 0);      // call 0x20
        rom[8'h08] = enc(0, 1, 1, 4, 1, 2);      // [0x12] = r4
        rom[8'h09] = enc(0, 2, 1, 15, 3, 0);     // r15 = 0x30
        rom[8'h20] = enc(3, 1, 1, 4, 0, 7);      // r4 = r0 | 0x80
        rom[8'h21] = enc(1, 0, 0, 4, 0, 0);      // push r4
        rom[8'h22] = enc(1, 2, 0, 5, 0, 0);      // pop r5
        rom[8'h23] = enc(3, 2, 1, 4, 5, 0);      // r4 = r5 ^ 0x01
        rom[8'h24] = enc(1, 2, 0, 15, 0, 0);     // return
        rom[8'h30] = enc(1, 3, 0, 0, 0, 0);      // undefined encoding
        rom[8'h31] = enc(2, 1, 1, 6, 0, 1);      // r6 = 0 - 1
        rom[8'h32] = enc(0, 3, 1, 5, 4, 0);      // branch signed less to 0x40
        rom[8'h33] = enc(0, 1, 1, 6, 1, 5);      // skipped
        rom[8'h40] = enc(0, 1, 1, 6, 1, 3);      // [0x13] = r6
        rom[8'h41] = enc(0, 3, 1, 9, 5, 0);      // code 9: never taken
        rom[8'h42] = enc(0, 1, 1, 1, 1, 4);      // [0x14] = r1
        rom[8'h43] = enc(0, 2, 1, 8, 1, 6);      // r8 = 0x16
        rom[8'h44] = enc(0, 0, 0, 9, 8, 13);     // r9 = [r8 - 3]
        rom[8'h45] = enc(0, 1, 0, 9, 8, 15);     // [r8 - 1] = r9
        rom[8'h46] = enc(0, 3, 0, 0, 15, 0);     // branch to r15 + 0 (self loop)

        do_reset();
        run_cycles(40);
        @(negedge clk);
        chk(ram[8'h10] == 8'h90, "R2", "add result", ram[8'h10], 8'h90);
        chk(ram[8'h11] == 8'h00, "R6", "skipped store", ram[8'h11], 0);
        chk(ram[8'h12] == 8'h81, "R3", "mask ops", ram[8'h12], 8'h81);
        chk(ram[8'hFF] == 8'h08, "R8", "return address at top", ram[8'hFF], 8'h08);
        chk(ram[8'hFE] == 8'h80, "R7", "pushed byte", ram[8'hFE], 8'h80);
        chk(ram[8'h13] == 8'hFF, "R5", "signed less branch", ram[8'h13], 8'hFF);
        chk(ram[8'h14] == 8'hC8, "R6", "never-taken code", ram[8'h14], 8'hC8);
        chk(ram[8'h15] == 8'hFF, "R4", "offset addressing", ram[8'h15], 8'hFF);
        chk(pmem_addr == 8'h46, "R9", "loop location", pmem_addr, 8'h46);

        // random instruction streams (R2 R3 R5 R7 R11 exercised in lockstep)
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < 256; i++) rom[i] = 17'($urandom);
            do_reset();
            run_cycles(1500);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule